// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block keeps the system-control state that a processor core with branch delay slots changes when it takes an exception. The pipeline presents a single-cycle fault request with a 5-bit exception code, plus the program counter of the faulting instruction and its successor. On that edge the block sets the exception-level flag in the status register. It writes the return address, corrected for a delay slot, into the exception PC register. It loads the code, the delay-slot flag and a cleared coprocessor field into the cause register. Under the conditions given below it also moves the shadow register-set selectors along.

One cycle after the request, the block presents a redirect strobe with the handler address. The address is formed from a base chosen by the boot-vector flag and an offset chosen by the exception class. A separate reset-entry request steers the core to the fixed reset handler and marks the boot vector and coprocessor 1 as enabled. Software can overwrite any of the four registers through a simple write port. A write made in the same cycle as an entry is dropped.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After rst_ni is released, status_o reads 0x00400000 (boot-vector flag, bit 22, set). cause_o, epc_o and srsctl_o read 0, and redirect_valid_o is 0.
- R2: Every accepted fault request sets the exception-level flag (status bit 1), whether or not it was already set. No other status bit changes.
- R3: On a fault entry with status bit 1 and bit 22 both 0, srsctl bits [9:6] take the old bits [3:0], and bits [3:0] take bits [15:12]. If either status bit is 1, srsctl_o is unchanged.
- R4: The instruction is in a delay slot when pc_i + 4 differs from npc_i. In that case epc_o is loaded with pc_i - 4 and cause bit 31 is set to 1. Otherwise epc_o is loaded with pc_i and cause bit 31 is cleared.
- R5: A fault entry writes fault_code_i into cause bits [6:2] and clears cause bits [29:28]. All other cause bits except bit 31 keep their value.
- R6: One cycle after a fault request, redirect_valid_o is 1 and redirect_pc_o equals base plus offset. The base is 0x80000000 when status bit 22 was 0 and 0xBFC00200 when it was 1. The offset is 0x000 for code 0 (interrupt) and 0x180 for every other code.
- R7: One cycle after reset_req_i, redirect_valid_o is 1 and redirect_pc_o is 0xBFC00000. Status bits 22 and 29 are set, and cause_o, epc_o and srsctl_o are unchanged. reset_req_i takes precedence over a fault request in the same cycle.
- R8: With no entry in that cycle, sw_we_i writes sw_wdata_i into the register picked by sw_sel_i (0 status, 1 cause, 2 exception PC, 3 shadow-set control). The new value is visible the next cycle.
- R9: A software write in the same cycle as a fault or reset entry is discarded in full.
- R10: redirect_valid_o is 0 in every cycle that does not directly follow a fault or reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_req_i | input | 1 | Single-cycle exception request |
| fault_code_i | input | 5 | Exception code of the request |
| pc_i | input | 32 | PC of the faulting instruction |
| npc_i | input | 32 | PC of the following instruction |
| reset_req_i | input | 1 | Reset-entry request |
| sw_we_i | input | 1 | Software register write enable |
| sw_sel_i | input | 2 | Software write target select |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC register |
| srsctl_o | output | 32 | Shadow register-set control register |
| redirect_valid_o | output | 1 | Handler redirect strobe |
| redirect_pc_o | output | 32 | Handler address |

## Verification
Two collisions can happen in one cycle. A software write can arrive together with a fault or reset entry, and a reset entry can arrive together with a fault request. Both are provoked by directed stimulus, for example a write of a marker value to the exception PC register alongside a fault. They are also provoked by random traffic that raises write enable, fault and reset requests independently. The outcome is judged against a behavioural model that drops the write and lets reset entry override the fault. The model is compared with every register and with the redirect outputs on every clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned SEL_W  = 2;

  // status fields
  localparam int unsigned ST_EXL = 1;
  localparam int unsigned ST_BEV = 22;
  localparam int unsigned ST_CU1 = 29;

  // cause fields
  localparam int unsigned CA_CODE_LO = 2;
  localparam int unsigned CA_CE_LO   = 28;
  localparam int unsigned CA_CE_W    = 2;
  localparam int unsigned CA_BD      = 31;

  // shadow-set control fields
  localparam int unsigned SRS_W      = 4;
  localparam int unsigned SRS_CSS_LO = 0;
  localparam int unsigned SRS_PSS_LO = 6;
  localparam int unsigned SRS_ESS_LO = 12;

  localparam logic [XLEN-1:0] STATUS_RST = 32'h0040_0000;

  localparam logic [CODE_W-1:0] CODE_INT = 5'd0;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_SRS    = 2'd3
  } cp0_sel_e;
endpackage

// File: rtl/exc_slot_decode.sv
module exc_slot_decode
  import exc_entry_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [XLEN-1:0] GEN_OFF = 32'h0000_0180
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   npc_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              delay_slot_o,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic [XLEN-1:0]   vec_off_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    delay_slot_o = (pc_i + STEP) != npc_i;
    ret_pc_o     = delay_slot_o ? (pc_i - STEP) : pc_i;
    vec_off_o    = (code_i == CODE_INT) ? '0 : GEN_OFF;
  end
endmodule

// File: rtl/exc_srs_ctl.sv
module exc_srs_ctl
  import exc_entry_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rotate_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] srsctl_o
);
  logic [XLEN-1:0] srs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srs_q <= '0;
    end else if (rotate_i) begin
      srs_q[SRS_PSS_LO +: SRS_W] <= srs_q[SRS_CSS_LO +: SRS_W];
      srs_q[SRS_CSS_LO +: SRS_W] <= srs_q[SRS_ESS_LO +: SRS_W];
    end else if (we_i) begin
      srs_q <= wdata_i;
    end
  end

  assign srsctl_o = srs_q;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] BASE_NORM = 32'h8000_0000,
  parameter logic [XLEN-1:0] BASE_BOOT = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fault_i,
  input  logic            reset_i,
  input  logic            bev_i,
  input  logic [XLEN-1:0] off_i,
  output logic            valid_o,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] tgt_d;

  always_comb begin
    if (reset_i)    tgt_d = RESET_VEC;
    else if (bev_i) tgt_d = BASE_BOOT + off_i;
    else            tgt_d = BASE_NORM + off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
    end else begin
      valid_o <= fault_i | reset_i;
      if (fault_i | reset_i) pc_o <= tgt_d;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [31:0] GEN_OFF    = 32'h0000_0180,
  parameter logic [31:0] BASE_NORM  = 32'h8000_0000,
  parameter logic [31:0] BASE_BOOT  = 32'hBFC0_0200,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fault_req_i,
  input  logic [4:0]  fault_code_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] npc_i,
  input  logic        reset_req_i,
  input  logic        sw_we_i,
  input  logic [1:0]  sw_sel_i,
  input  logic [31:0] sw_wdata_i,
  output logic [31:0] status_o,
  output logic [31:0] cause_o,
  output logic [31:0] epc_o,
  output logic [31:0] srsctl_o,
  output logic        redirect_valid_o,
  output logic [31:0] redirect_pc_o
);
  logic [XLEN-1:0] status_q, cause_q, epc_q;
  logic            fault_take, sw_ok, rotate;
  logic            delay_slot;
  logic [XLEN-1:0] ret_pc, vec_off;
  cp0_sel_e        sel;

  assign sel        = cp0_sel_e'(sw_sel_i);
  assign fault_take = fault_req_i & ~reset_req_i;
  assign sw_ok      = sw_we_i & ~fault_req_i & ~reset_req_i;
  assign rotate     = fault_take & ~status_q[ST_EXL] & ~status_q[ST_BEV];

  exc_slot_decode #(
    .INSN_BYTES(INSN_BYTES),
    .GEN_OFF   (GEN_OFF)
  ) u_decode (
    .pc_i        (pc_i),
    .npc_i       (npc_i),
    .code_i      (fault_code_i),
    .delay_slot_o(delay_slot),
    .ret_pc_o    (ret_pc),
    .vec_off_o   (vec_off)
  );

  exc_srs_ctl u_srs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rotate_i(rotate),
    .we_i    (sw_ok && sel == SEL_SRS),
    .wdata_i (sw_wdata_i),
    .srsctl_o(srsctl_o)
  );

  exc_vector_gen #(
    .BASE_NORM(BASE_NORM),
    .BASE_BOOT(BASE_BOOT),
    .RESET_VEC(RESET_VEC)
  ) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_take),
    .reset_i(reset_req_i),
    .bev_i  (status_q[ST_BEV]),
    .off_i  (vec_off),
    .valid_o(redirect_valid_o),
    .pc_o   (redirect_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
    end else if (reset_req_i) begin
      status_q[ST_BEV] <= 1'b1;
      status_q[ST_CU1] <= 1'b1;
    end else if (fault_take) begin
      status_q[ST_EXL] <= 1'b1;
    end else if (sw_ok && sel == SEL_STATUS) begin
      status_q <= sw_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (fault_take) begin
      cause_q[CA_CODE_LO +: CODE_W]  <= fault_code_i;
      cause_q[CA_CE_LO +: CA_CE_W]   <= '0;
      cause_q[CA_BD]                 <= delay_slot;
    end else if (sw_ok && sel == SEL_CAUSE) begin
      cause_q <= sw_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q <= '0;
    end else if (fault_take) begin
      epc_q <= ret_pc;
    end else if (sw_ok && sel == SEL_EPC) begin
      epc_q <= sw_wdata_i;
    end
  end

  assign status_o = status_q;
  assign cause_o  = cause_q;
  assign epc_o    = epc_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fault_req_i,
  input logic [4:0]  fault_code_i,
  input logic [31:0] pc_i,
  input logic [31:0] npc_i,
  input logic        reset_req_i,
  input logic        sw_we_i,
  input logic [1:0]  sw_sel_i,
  input logic [31:0] sw_wdata_i,
  input logic [31:0] status_o,
  input logic [31:0] cause_o,
  input logic [31:0] epc_o,
  input logic [31:0] srsctl_o,
  input logic        redirect_valid_o,
  input logic [31:0] redirect_pc_o
);
  a_r2_exl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i && !reset_req_i |=> status_o[1]);

  a_r3_srs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i && !reset_req_i && (status_o[1] || status_o[22]) |=> $stable(srsctl_o));

  a_r4_slot_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i && !reset_req_i && (pc_i + 32'd4 != npc_i)
    |=> cause_o[31] && (epc_o == $past(pc_i) - 32'd4));

  a_r5_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req_i && !reset_req_i |=> cause_o[6:2] == $past(fault_code_i) && cause_o[29:28] == 2'b00);

  a_r7_reset_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> redirect_valid_o && redirect_pc_o == 32'hBFC0_0000 && status_o[29] && status_o[22]);

  a_r9_sw_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i && sw_we_i && sw_sel_i == 2'd2 |=> $stable(epc_o));

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_req_i || reset_req_i) |=> !redirect_valid_o);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_req = 1'b0;
  logic [4:0]  fault_code = '0;
  logic [31:0] pc = '0, npc = 32'd4;
  logic        reset_req = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] status, cause, epc, srsctl, rpc;
  logic        rvalid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_st, m_ca, m_epc, m_srs, m_rpc;
  logic        m_rv;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fault_req_i(fault_req), .fault_code_i(fault_code),
    .pc_i(pc), .npc_i(npc), .reset_req_i(reset_req),
    .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .status_o(status), .cause_o(cause), .epc_o(epc), .srsctl_o(srsctl),
    .redirect_valid_o(rvalid), .redirect_pc_o(rpc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 32'h0040_0000; m_ca = 0; m_epc = 0; m_srs = 0; m_rv = 0; m_rpc = 0;
    end else if (reset_req) begin
      m_rv = 1; m_rpc = 32'hBFC0_0000;
      m_st[22] = 1; m_st[29] = 1;
    end else if (fault_req) begin
      bit ds;
      ds = (pc + 32'd4) != npc;
      m_rv = 1;
      m_rpc = (m_st[22] ? 32'hBFC0_0200 : 32'h8000_0000) + ((fault_code == 0) ? 32'h0 : 32'h180);
      if (!m_st[1] && !m_st[22]) begin
        m_srs[9:6] = m_srs[3:0];
        m_srs[3:0] = m_srs[15:12];
      end
      m_st[1] = 1;
      m_epc = ds ? pc - 32'd4 : pc;
      m_ca[6:2] = fault_code; m_ca[29:28] = 2'b00; m_ca[31] = ds;
    end else begin
      m_rv = 0;
      if (sw_we) begin
        case (sw_sel)
          2'd0: m_st = sw_wdata;
          2'd1: m_ca = sw_wdata;
          2'd2: m_epc = sw_wdata;
          default: m_srs = sw_wdata;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 status", status, m_st);
      check("R5 cause", cause, m_ca);
      check("R4 epc", epc, m_epc);
      check("R3 srsctl", srsctl, m_srs);
      check("R10 redirect_valid", {31'd0, rvalid}, {31'd0, m_rv});
      if (m_rv) check("R6 redirect_pc", rpc, m_rpc);
    end
  end

  task automatic idle();
    fault_req = 0; reset_req = 0; sw_we = 0;
  endtask

  task automatic do_fault(logic [4:0] c, logic [31:0] p, logic [31:0] n);
    fault_req = 1; fault_code = c; pc = p; npc = n;
    @(negedge clk);
    idle();
  endtask

  task automatic do_write(logic [1:0] s, logic [31:0] d);
    sw_we = 1; sw_sel = s; sw_wdata = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 32'h0040_0000);
    check("R1 cause", cause, 0);
    check("R1 epc", epc, 0);
    check("R1 srsctl", srsctl, 0);
    check("R1 valid", {31'd0, rvalid}, 0);

    // BEV=1: syscall, no slot; srs must hold
    do_fault(5'd8, 32'h100, 32'h104);
    check("R6 boot vector", rpc, 32'hBFC0_0380);
    check("R2 exl", {31'd0, status[1]}, 1);
    check("R3 hold bev", srsctl, 0);
    check("R4 epc", epc, 32'h100);
    @(negedge clk);
    check("R10 pulse", {31'd0, rvalid}, 0);

    // R8 software setup
    do_write(2'd0, 32'h0000_0000);
    check("R8 status write", status, 0);
    do_write(2'd3, 32'h0000_5002);
    check("R8 srs write", srsctl, 32'h0000_5002);
    do_write(2'd1, 32'h3000_0000);

    // rotation with EXL=BEV=0
    do_fault(5'd12, 32'h200, 32'h204);
    check("R3 rotate", srsctl, 32'h0000_5085);
    check("R6 normal vector", rpc, 32'h8000_0180);
    check("R5 ce clear", cause, 32'h0000_0030);
    // EXL now set: no rotation
    do_fault(5'd9, 32'h300, 32'h304);
    check("R3 hold exl", srsctl, 32'h0000_5085);

    // delay slot, interrupt code
    do_write(2'd0, 32'h0000_0000);
    do_fault(5'd0, 32'h400, 32'h800);
    check("R4 slot epc", epc, 32'h3FC);
    check("R4 bd", {31'd0, cause[31]}, 1);
    check("R6 int vector", rpc, 32'h8000_0000);

    // R9 write collides with fault
    sw_we = 1; sw_sel = 2'd2; sw_wdata = 32'hDEAD_BEEF;
    do_fault(5'd10, 32'h500, 32'h504);
    check("R9 write dropped", epc, 32'h500);

    // R7 reset beats fault and write
    sw_we = 1; sw_sel = 2'd1; sw_wdata = 32'hFFFF_FFFF;
    reset_req = 1;
    do_fault(5'd13, 32'h600, 32'h604);
    check("R7 reset vector", rpc, 32'hBFC0_0000);
    check("R7 cu1 bev", {30'd0, status[29], status[22]}, 32'd3);
    check("R7 epc kept", epc, 32'h500);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      fault_req  = ($urandom_range(0, 3) == 0);
      reset_req  = ($urandom_range(0, 19) == 0);
      sw_we      = ($urandom_range(0, 2) == 0);
      sw_sel     = 2'($urandom_range(0, 3));
      sw_wdata   = $urandom;
      fault_code = 5'($urandom_range(0, 31));
      pc         = {$urandom, 2'b00};
      npc        = ($urandom_range(0, 1) == 0) ? pc + 32'd4 : {$urandom, 2'b00};
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule